// File: doc/BRIEF.md
# Microsecond Timestamp Counter with Fractional Prescaler

This block keeps a free-running up-counter that software reads as a timestamp in microseconds. It is clocked by the system clock and receives a one-cycle enable for each oscillator period. A fractional prescaler turns that enable stream into a microsecond tick. Each tick advances the counter by one. When the counter passes its all-ones value it returns to zero silently, and the block has no interrupt of any kind.

The prescaler ratio is programmed as two fields, each stored minus one. On every oscillator enable an accumulator gains the multiplier M (the stored field plus one). When the accumulator reaches or exceeds the modulus D (the other stored field plus one), D is taken off and one tick is emitted. A freeze bit stops both the counter and the accumulator. The reset ratio suits a 12 MHz oscillator and gives a 1 MHz tick. The counter needs no setup and starts advancing right after reset.

Register access uses a simple bus. A write is a single-cycle strobe with an address and data. A read is combinational from the address. Accesses are word-aligned and use byte offsets.

Top module: `usec_stamp_timer`

## Requirements
- R1: After reset the counter reads 0, the ratio register reads 0x0000000B and the freeze register reads 0.
- R2: Offset 0x00 reads the counter, zero-extended. Offset 0x04 holds the ratio: bits 15:8 are M-1 and bits 7:0 are D-1, and bits 31:16 read 0. Offset 0x3C holds the freeze flag in bit 0, and its other bits read 0. Any other offset reads 0.
- R3: Each enabled, unfrozen oscillator pulse adds M to the accumulator. When the sum is at least D, D is subtracted and the counter rises by one. With M not above D and a cleared accumulator, N pulses raise the counter by floor(N*M/D).
- R4: With the reset ratio 0x0B (M=1, D=12), the counter rises exactly once per 12 oscillator pulses.
- R5: When M exceeds D, every enabled, unfrozen oscillator pulse raises the counter by one and leaves the accumulator at zero.
- R6: In cycles without an oscillator enable, the counter and the accumulator keep their values.
- R7: While the freeze flag is 1, the counter and the accumulator keep their values. After the flag clears, counting resumes from the held accumulator.
- R8: A write to the ratio register clears the accumulator. It emits no tick in that cycle, and the new ratio applies from the next pulse.
- R9: The counter wraps from all-ones to zero.
- R10: Writes to offset 0x00 and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The checker watches several properties on every cycle. The counter moves by at most one step per cycle and holds in cycles without an enable and while frozen. The accumulator stays below the modulus and is zero after a ratio write. With a ratio above one, each pulse gives a tick. All-ones is followed by zero or all-ones. The bench scenarios show what single-cycle properties cannot: the exact tick count over long runs of pulses for integer and fractional ratios, the accumulator held across a freeze, the register read-back and masking, writes that are ignored, and a real wrap on a narrow instance.

// File: rtl/stamp_pkg.sv
// Shared constants and types for the microsecond timestamp counter.
// Assumes a 32-bit data bus and an 8-bit byte-offset address.
package stamp_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int FIELD_W = 8;
    localparam int ACC_W   = FIELD_W + 1;   // holds values below D <= 2**FIELD_W
    localparam int SUM_W   = FIELD_W + 2;   // accumulator plus multiplier

    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RATIO  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_FREEZE = 8'h3C;

    // Ratio register fields, each stored minus one.
    typedef struct packed {
        logic [FIELD_W-1:0] mul_m1;   // bits 15:8
        logic [FIELD_W-1:0] mod_m1;   // bits 7:0
    } ratio_t;

    localparam ratio_t RATIO_RESET = '{mul_m1: 8'd0, mod_m1: 8'd11};
endpackage

// File: rtl/stamp_regs.sv
// Register file: ratio and freeze registers, write decode and read mux.
// Assumes single-cycle write strobes; reads are combinational.
module stamp_regs #(
    parameter int COUNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [stamp_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [stamp_pkg::DATA_W-1:0]  bus_wdata,
    input  logic [COUNT_W-1:0]            count,
    output stamp_pkg::ratio_t             ratio,
    output logic                          frozen,
    output logic                          ratio_wr,
    output logic [stamp_pkg::DATA_W-1:0]  bus_rdata
);
    import stamp_pkg::*;

    localparam int RATIO_W = 2 * FIELD_W;

    ratio_t ratio_q;
    logic   freeze_q;
    logic   freeze_wr;
    logic   unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:RATIO_W];

    // Decode write strobes per register.
    always_comb begin
        ratio_wr  = bus_wr && (bus_addr == OFS_RATIO);
        freeze_wr = bus_wr && (bus_addr == OFS_FREEZE);
    end

    // Ratio register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ratio_q <= RATIO_RESET;
        else if (ratio_wr)
            ratio_q <= ratio_t'(bus_wdata[RATIO_W-1:0]);
    end

    // Freeze flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            freeze_q <= 1'b0;
        else if (freeze_wr)
            freeze_q <= bus_wdata[0];
    end

    // Read mux by offset; unmapped offsets read zero.
    always_comb begin
        case (bus_addr)
            OFS_COUNT:  bus_rdata = DATA_W'(count);
            OFS_RATIO:  bus_rdata = DATA_W'(ratio_q);
            OFS_FREEZE: bus_rdata = DATA_W'(freeze_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign ratio  = ratio_q;
    assign frozen = freeze_q;
endmodule

// File: rtl/stamp_prescaler.sv
// Fractional prescaler: adds M per oscillator pulse and emits a tick
// when the sum reaches D. Assumes osc_en is one system-clock cycle wide.
module stamp_prescaler (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         osc_en,
    input  logic                         frozen,
    input  logic                         clear,
    input  stamp_pkg::ratio_t            ratio,
    output logic                         tick,
    output logic [stamp_pkg::ACC_W-1:0]  acc
);
    import stamp_pkg::*;

    logic [ACC_W-1:0] acc_q, acc_d;
    logic [SUM_W-1:0] step, modulus, sum, rem;
    logic             advance, reached, fast;

    // Derive step, modulus and the candidate next value.
    always_comb begin
        step    = SUM_W'(ratio.mul_m1) + SUM_W'(1);
        modulus = SUM_W'(ratio.mod_m1) + SUM_W'(1);
        sum     = SUM_W'(acc_q) + step;
        rem     = sum - modulus;
        fast    = step > modulus;
        reached = sum >= modulus;
        advance = osc_en && !frozen && !clear;
        tick    = advance && reached;
    end

    // Select the next accumulator value.
    always_comb begin
        if (clear)
            acc_d = '0;
        else if (!advance)
            acc_d = acc_q;
        else if (fast)
            acc_d = '0;
        else if (reached)
            acc_d = rem[ACC_W-1:0];
        else
            acc_d = sum[ACC_W-1:0];
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    assign acc = acc_q;
endmodule

// File: rtl/stamp_counter.sv
// Up-counter advanced by the prescaler tick; wraps silently.
module stamp_counter #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    output logic [COUNT_W-1:0] count
);
    // Count ticks with modular wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick)
            count <= count + COUNT_W'(1);
    end
endmodule

// File: rtl/usec_stamp_timer.sv
// Top: microsecond timestamp counter with a fractional prescaler.
// Assumes all inputs are synchronous to clk; COUNT_W must not exceed 32.
module usec_stamp_timer #(
    parameter int COUNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_en,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    import stamp_pkg::*;

    ratio_t             ratio_s;
    logic               frozen_s;
    logic               ratio_wr_s;
    logic               tick_s;
    logic [ACC_W-1:0]   acc_s;
    logic [COUNT_W-1:0] count_s;

    stamp_regs #(.COUNT_W(COUNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count_s),
        .ratio     (ratio_s),
        .frozen    (frozen_s),
        .ratio_wr  (ratio_wr_s),
        .bus_rdata (bus_rdata)
    );

    stamp_prescaler u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .frozen (frozen_s),
        .clear  (ratio_wr_s),
        .ratio  (ratio_s),
        .tick   (tick_s),
        .acc    (acc_s)
    );

    stamp_counter #(.COUNT_W(COUNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_s),
        .count (count_s)
    );
endmodule

// File: rtl/stamp_checker.sv
// Cycle-level properties of the timestamp counter, bound into the top.
module stamp_checker #(
    parameter int COUNT_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        osc_en,
    input logic                        frozen,
    input logic                        ratio_wr,
    input stamp_pkg::ratio_t           ratio,
    input logic [stamp_pkg::ACC_W-1:0] acc,
    input logic [COUNT_W-1:0]          count
);
    import stamp_pkg::*;

    logic [SUM_W-1:0] mod_v, mul_v;
    assign mod_v = SUM_W'(ratio.mod_m1) + SUM_W'(1);
    assign mul_v = SUM_W'(ratio.mul_m1) + SUM_W'(1);

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + COUNT_W'(1)));

    a_r3_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(acc) < mod_v);

    a_r5_fast_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_v > mod_v && osc_en && !frozen && !ratio_wr)
        |=> (count == $past(count) + COUNT_W'(1)) && (acc == '0));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !ratio_wr) |=> $stable(count) && $stable(acc));

    a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !ratio_wr) |=> $stable(count) && $stable(acc));

    a_r8_ratio_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_wr |=> (acc == '0) && $stable(count));

    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (&count) |=> (count == '0) || (&count));
endmodule

bind usec_stamp_timer stamp_checker #(.COUNT_W(COUNT_W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .frozen   (frozen_s),
    .ratio_wr (ratio_wr_s),
    .ratio    (ratio_s),
    .acc      (acc_s),
    .count    (count_s)
);

// File: tb/test_usec_stamp_timer.sv
module test_usec_stamp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata8;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    usec_stamp_timer i_usec_stamp_timer (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata));

    usec_stamp_timer #(.COUNT_W(8)) i_usec_stamp_timer_w8 (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata8));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d8);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = rdata; d8 = rdata8;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            osc_en = 1'b1;
        end
        @(negedge clk);
        osc_en = 1'b0;
    endtask

    function automatic logic [31:0] cnt_now();
        return 32'h0;
    endfunction

    task automatic t_reset();
        logic [31:0] d, d8;
        rd(8'h00, d, d8); check("R1 counter", d, 32'h0);
        rd(8'h04, d, d8); check("R1 ratio", d, 32'h0000000B);
        rd(8'h3C, d, d8); check("R1 freeze", d, 32'h0);
    endtask

    task automatic t_default_ratio();
        logic [31:0] d, d8;
        pulses(11); rd(8'h00, d, d8); check("R4 11 pulses", d, 32'd0);
        pulses(1);  rd(8'h00, d, d8); check("R4 12th pulse", d, 32'd1);
        pulses(120); rd(8'h00, d, d8); check("R4 120 more", d, 32'd11);
    endtask

    task automatic t_fraction();
        logic [31:0] d, d8, base;
        wr(8'h04, 32'h0000_0206);              // M=3, D=7
        rd(8'h00, base, d8);
        pulses(2); rd(8'h00, d, d8); check("R3 frac 2", d, base);
        pulses(1); rd(8'h00, d, d8); check("R3 frac 3", d, base + 1);
        pulses(67); rd(8'h00, d, d8); check("R3 frac 70", d, base + 30);
    endtask

    task automatic t_idle();
        logic [31:0] d, d8, base;
        rd(8'h00, base, d8);
        repeat (40) @(negedge clk);
        rd(8'h00, d, d8); check("R6 idle hold", d, base);
    endtask

    task automatic t_ratio_clear();
        logic [31:0] d, d8, base;
        wr(8'h04, 32'h0000_000B);
        rd(8'h00, base, d8);
        pulses(11);
        wr(8'h04, 32'h0000_000B);
        pulses(11); rd(8'h00, d, d8); check("R8 cleared acc", d, base);
        pulses(1);  rd(8'h00, d, d8); check("R8 new period", d, base + 1);
    endtask

    task automatic t_freeze();
        logic [31:0] d, d8, base;
        wr(8'h04, 32'h0000_000B);
        rd(8'h00, base, d8);
        pulses(6);
        wr(8'h3C, 32'h1);
        rd(8'h3C, d, d8); check("R7 freeze reads 1", d, 32'h1);
        pulses(30); rd(8'h00, d, d8); check("R7 frozen count", d, base);
        wr(8'h3C, 32'h0);
        pulses(5); rd(8'h00, d, d8); check("R7 acc held 11", d, base);
        pulses(1); rd(8'h00, d, d8); check("R7 resumes", d, base + 1);
    endtask

    task automatic t_fast();
        logic [31:0] d, d8, base;
        wr(8'h04, 32'hFFFF_0501);              // M=6, D=2
        rd(8'h04, d, d8); check("R2 ratio mask", d, 32'h0000_0501);
        rd(8'h00, base, d8);
        pulses(10); rd(8'h00, d, d8); check("R5 fast ratio", d, base + 10);
        wr(8'h04, 32'h0000_0000);              // M=D=1
        rd(8'h00, base, d8);
        pulses(7); rd(8'h00, d, d8); check("R3 unity ratio", d, base + 7);
    endtask

    task automatic t_regs();
        logic [31:0] d, d8, base;
        wr(8'h3C, 32'hFFFF_FFFE);
        rd(8'h3C, d, d8); check("R2 freeze bit0 only", d, 32'h0);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h3C, d, d8); check("R2 freeze upper bits", d, 32'h1);
        wr(8'h3C, 32'h0);
        rd(8'h10, d, d8); check("R2 unmapped read", d, 32'h0);
        rd(8'h00, base, d8);
        wr(8'h00, 32'h1234_5678);
        rd(8'h00, d, d8); check("R10 counter write ignored", d, base);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h04, d, d8); check("R10 unmapped write ratio", d, 32'h0);
        rd(8'h3C, d, d8); check("R10 unmapped write freeze", d, 32'h0);
    endtask

    task automatic t_wrap();
        logic [31:0] d, d8, base, b8;
        int n;
        wr(8'h04, 32'h0);
        rd(8'h00, base, b8);
        check("R9 narrow tracks", b8, base & 32'hFF);
        n = 256 - int'(b8);
        pulses(n - 1); rd(8'h00, d, d8); check("R9 at all-ones", d8, 32'hFF);
        pulses(1); rd(8'h00, d, d8); check("R9 wrapped", d8, 32'h0);
        check("R9 wide continues", d, base + n);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_ratio();
        t_fraction();
        t_idle();
        t_ratio_clear();
        t_freeze();
        t_fast();
        t_regs();
        t_wrap();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule